// File: doc/BRIEF.md
# Space-Tagged Translation Lookaside Buffer

This block is a fully associative translation buffer in which every entry carries a 2-bit space identifier beside its virtual page number. Because of the tag, a native host address space and several foreign-guest address spaces can share one array without flushing it when execution switches between them. Each entry also stores a page mask, so small guest pages and larger host pages can coexist in the array.

The identifier of each lookup is chosen by a small context unit. An armed one-shot prefix supplies the identifier for the next lookup only. Otherwise a global context register, which resets to 0, supplies it. A lookup returns the physical page and the write permission. When no valid translation exists, or a store finds no write permission, the block instead reports the kind of fault and a handler vector. That vector is different for guest identifiers and host identifiers.

Software loads entries one at a time at an index it chooses. It can drop all entries of one identifier with one flush command, and the other spaces stay intact.

Top module: `mid_tlb`

## Requirements
- R1: A live entry matches only when its identifier equals the lookup identifier and its VPN equals `lk_vpn` in every bit the entry's mask leaves clear. A set mask bit k ignores VPN bit k. On a hit, `rsp_ppn` is the stored PPN, with its masked low bits taken from `lk_vpn`.
- R2: The global context resets to 0. Writing it with `ctx_we` takes effect for lookups in later cycles. A lookup with no armed prefix uses the context.
- R3: `pfx_set` arms a prefix carrying `pfx_id`. The next lookup uses that identifier and consumes the prefix, and the lookup after it falls back to the context.
- R4: A lookup that faults disarms the prefix, and this includes a prefix set in the same cycle. A prefix set in the same cycle as a lookup that hits stays armed for the following lookup, and that same-cycle lookup does not use it.
- R5: Each lookup gives a response one cycle later, with `rsp_valid` high. `exc_kind` is 0 for a hit, 1 when no entry matches, 2 when the matching entry has its valid bit clear, and 3 when a store hits a valid entry whose dirty bit is clear. Without a lookup, `rsp_valid` is 0.
- R6: On a fault, `exc_vec` is `GUEST_VEC` (default 32'h400) for identifiers 2 and 3 and `HOST_VEC` (default 32'h180) for identifiers 0 and 1. `exc_id` gives the identifier that was used.
- R7: A refill writes every field of the entry at `rf_idx` and makes it live. A lookup in the same cycle sees the contents from before the write.
- R8: A flush makes non-live only the entries whose identifier equals `fl_id`. A refill in the same cycle takes effect after the flush.
- R9: When several entries match, the lowest index supplies the result and `multi_err` is set. `multi_err` stays set until reset.
- R10: After reset every entry is non-live, so every lookup misses, and `multi_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_set | input | 1 | Arm one-shot identifier prefix |
| pfx_id | input | 2 | Prefix identifier |
| ctx_we | input | 1 | Write global context |
| ctx_id | input | 2 | New global context |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is a store |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| rf_we | input | 1 | Refill write enable |
| rf_idx | input | IDX_W | Refill entry index |
| rf_id | input | 2 | Refill identifier |
| rf_vpn | input | VPN_W | Refill VPN |
| rf_mask | input | MASK_W | Refill page mask |
| rf_ppn | input | PPN_W | Refill PPN |
| rf_v | input | 1 | Refill valid bit |
| rf_d | input | 1 | Refill dirty/writable bit |
| fl_req | input | 1 | Flush by identifier |
| fl_id | input | 2 | Identifier to flush |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup translated |
| rsp_ppn | output | PPN_W | Translated page |
| rsp_wr | output | 1 | Page writable |
| exc_kind | output | 2 | Fault kind |
| exc_id | output | 2 | Identifier used by the lookup |
| exc_vec | output | VEC_W | Handler vector |
| multi_err | output | 1 | Sticky multiple-match flag |

## Verification
Two events meet in one cycle in the most delicate case: arming a prefix and a lookup. Whether the new prefix survives depends on whether that lookup faults. The bench drives both cases directly. In one, a prefix is armed alongside a lookup that hits, and the next lookup must use the new identifier. In the other, a prefix is armed alongside a lookup that misses, and the next lookup must fall back to the context. Random traffic then makes these coincidences, and refills, flushes or context writes landing on a lookup cycle, happen often. Each response is compared with a reference model that advances only after it has computed that cycle's expected result.

// File: rtl/mtlb_pkg.sv
// Shared encodings for the space-tagged translation buffer.
// Assumes a 2-bit space identifier; identifier values 2 and 3 are guest spaces.
package mtlb_pkg;
    typedef enum logic [1:0] {
        XK_NONE    = 2'd0,
        XK_MISS    = 2'd1,
        XK_INVALID = 2'd2,
        XK_MODIFY  = 2'd3
    } xkind_t;

    localparam int SID_W = 2;
endpackage

// File: rtl/mtlb_ctx.sv
// Identifier context: global context register plus one-shot prefix.
// Assumes lk_fault is valid combinationally in the cycle of lk_req.
module mtlb_ctx
    import mtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfx_set,
    input  logic [SID_W-1:0] pfx_id,
    input  logic             ctx_we,
    input  logic [SID_W-1:0] ctx_id,
    input  logic             lk_req,
    input  logic             lk_fault,
    output logic [SID_W-1:0] eid
);
    logic             pend;
    logic [SID_W-1:0] pid_q;
    logic [SID_W-1:0] ctx_q;

    // Effective identifier: armed prefix wins over the global context.
    always_comb eid = pend ? pid_q : ctx_q;

    // Context register update.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctx_q <= '0;
        else if (ctx_we) ctx_q <= ctx_id;
    end

    // Prefix arm / consume / drop on fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            pid_q <= '0;
        end else if (lk_req && lk_fault) begin
            pend  <= 1'b0;
        end else if (pfx_set) begin
            pend  <= 1'b1;
            pid_q <= pfx_id;
        end else if (lk_req) begin
            pend  <= 1'b0;
        end
    end

    a_r3_consume: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && !pfx_set |=> !pend);
    a_r4_fault_drop: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && lk_fault |=> !pend);
    a_r2_ctx_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_we |=> ctx_q == $past(ctx_id));
endmodule

// File: rtl/mtlb_pick.sv
// Lowest-index priority picker with multiple-match detection.
// Assumes ENTRIES is a power of two or IDX_W covers it.
module mtlb_pick #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vec,
    output logic [IDX_W-1:0]   idx,
    output logic               any,
    output logic               multi
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end

    // Any match and more-than-one match flags.
    always_comb begin
        any   = |vec;
        multi = |(vec & (vec - ENTRIES'(1)));
    end

    a_r9_multi_any: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> any && $countones(vec) > 1);
endmodule

// File: rtl/mtlb_array.sv
// Entry storage and parallel tag compare for the translation buffer.
// Assumes one refill and one flush per cycle; refill applies after flush.
module mtlb_array
    import mtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 36,
    parameter int PPN_W   = 28,
    parameter int MASK_W  = 2,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rf_we,
    input  logic [IDX_W-1:0]   rf_idx,
    input  logic [SID_W-1:0]   rf_id,
    input  logic [VPN_W-1:0]   rf_vpn,
    input  logic [MASK_W-1:0]  rf_mask,
    input  logic [PPN_W-1:0]   rf_ppn,
    input  logic               rf_v,
    input  logic               rf_d,
    input  logic               fl_req,
    input  logic [SID_W-1:0]   fl_id,
    input  logic [SID_W-1:0]   q_id,
    input  logic [VPN_W-1:0]   q_vpn,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [PPN_W-1:0]   sel_ppn,
    output logic [MASK_W-1:0]  sel_mask,
    output logic               sel_v,
    output logic               sel_d
);
    logic [ENTRIES-1:0] live;
    logic [SID_W-1:0]   id_q   [ENTRIES];
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [MASK_W-1:0]  mask_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [ENTRIES-1:0] v_q;
    logic [ENTRIES-1:0] d_q;

    // Flush by identifier, then refill the indexed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fl_req && id_q[i] == fl_id) live[i] <= 1'b0;
                if (rf_we && rf_idx == IDX_W'(i)) begin
                    live[i]   <= 1'b1;
                    id_q[i]   <= rf_id;
                    vpn_q[i]  <= rf_vpn;
                    mask_q[i] <= rf_mask;
                    ppn_q[i]  <= rf_ppn;
                    v_q[i]    <= rf_v;
                    d_q[i]    <= rf_d;
                end
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VPN_W-1:0] care;
        // Per-entry compare of tag and unmasked VPN bits.
        assign care       = ~{{(VPN_W-MASK_W){1'b0}}, mask_q[g]};
        assign hit_vec[g] = live[g] && (id_q[g] == q_id)
                            && (((vpn_q[g] ^ q_vpn) & care) == '0);

        a_r7_refill: assert property (@(posedge clk) disable iff (!rst_n)
            rf_we && rf_idx == IDX_W'(g) |=> live[g] && id_q[g] == $past(rf_id));
        a_r8_flush_spare: assert property (@(posedge clk) disable iff (!rst_n)
            fl_req && id_q[g] != fl_id && !(rf_we && rf_idx == IDX_W'(g))
            |=> live[g] == $past(live[g]));
    end

    // Read port for the selected entry.
    always_comb begin
        sel_ppn  = ppn_q[sel_idx];
        sel_mask = mask_q[sel_idx];
        sel_v    = v_q[sel_idx];
        sel_d    = d_q[sel_idx];
    end
endmodule

// File: rtl/mid_tlb.sv
// Top: space-tagged fully associative translation buffer.
// Lookups resolve in their request cycle and are reported one cycle later.
module mid_tlb
    import mtlb_pkg::*;
#(
    parameter int          ENTRIES   = 64,
    parameter int          VPN_W     = 36,
    parameter int          PPN_W     = 28,
    parameter int          MASK_W    = 2,
    parameter int          VEC_W     = 32,
    parameter logic [31:0] HOST_VEC  = 32'h0000_0180,
    parameter logic [31:0] GUEST_VEC = 32'h0000_0400,
    localparam int         IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_set,
    input  logic [1:0]        pfx_id,
    input  logic              ctx_we,
    input  logic [1:0]        ctx_id,
    input  logic              lk_req,
    input  logic              lk_store,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_idx,
    input  logic [1:0]        rf_id,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [MASK_W-1:0] rf_mask,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_v,
    input  logic              rf_d,
    input  logic              fl_req,
    input  logic [1:0]        fl_id,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_wr,
    output logic [1:0]        exc_kind,
    output logic [1:0]        exc_id,
    output logic [VEC_W-1:0]  exc_vec,
    output logic              multi_err
);
    logic [SID_W-1:0]   eid;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   sel_idx;
    logic               any, multi;
    logic [PPN_W-1:0]   sel_ppn;
    logic [MASK_W-1:0]  sel_mask;
    logic               sel_v, sel_d;
    logic               ok, fault;
    xkind_t             kind;
    logic [PPN_W-1:0]   pmask, ppn_out;

    mtlb_ctx u_ctx (
        .clk(clk), .rst_n(rst_n), .pfx_set(pfx_set), .pfx_id(pfx_id),
        .ctx_we(ctx_we), .ctx_id(ctx_id), .lk_req(lk_req),
        .lk_fault(fault), .eid(eid)
    );

    mtlb_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
                 .MASK_W(MASK_W), .IDX_W(IDX_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_id(rf_id), .rf_vpn(rf_vpn), .rf_mask(rf_mask), .rf_ppn(rf_ppn),
        .rf_v(rf_v), .rf_d(rf_d), .fl_req(fl_req), .fl_id(fl_id),
        .q_id(eid), .q_vpn(lk_vpn), .sel_idx(sel_idx), .hit_vec(hit_vec),
        .sel_ppn(sel_ppn), .sel_mask(sel_mask), .sel_v(sel_v), .sel_d(sel_d)
    );

    mtlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .vec(hit_vec),
        .idx(sel_idx), .any(any), .multi(multi)
    );

    // Classify the lookup and form the translated page.
    always_comb begin
        if (!any)                      kind = XK_MISS;
        else if (!sel_v)               kind = XK_INVALID;
        else if (lk_store && !sel_d)   kind = XK_MODIFY;
        else                           kind = XK_NONE;
        ok      = (kind == XK_NONE);
        fault   = lk_req && !ok;
        pmask   = {{(PPN_W-MASK_W){1'b0}}, sel_mask};
        ppn_out = (sel_ppn & ~pmask)
                | ({{(PPN_W-MASK_W){1'b0}}, lk_vpn[MASK_W-1:0]} & pmask);
    end

    // Register the response and the sticky multiple-match flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_wr    <= 1'b0;
            exc_kind  <= XK_NONE;
            exc_id    <= '0;
            exc_vec   <= '0;
            multi_err <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && ok;
            rsp_ppn   <= (lk_req && ok) ? ppn_out : '0;
            rsp_wr    <= lk_req && ok && sel_d;
            exc_kind  <= lk_req ? kind : XK_NONE;
            exc_id    <= lk_req ? eid : '0;
            exc_vec   <= fault ? VEC_W'(eid[1] ? GUEST_VEC : HOST_VEC) : '0;
            multi_err <= multi_err || (lk_req && multi);
        end
    end

    a_r5_resp: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> exc_kind == XK_NONE && !rsp_hit);
    a_r6_vec: assert property (@(posedge clk) disable iff (!rst_n)
        exc_kind != XK_NONE |-> exc_vec == VEC_W'(exc_id[1] ? GUEST_VEC : HOST_VEC));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |=> multi_err);
endmodule

// File: tb/sim_mid_tlb.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module sim_mid_tlb;
    localparam int TCLK = 10;
    localparam int N = 64, VW = 36, PW = 28, MW = 2;
    localparam logic [31:0] HV = 32'h180, GV = 32'h400;

    logic clk = 0, rst_n = 0;
    logic pfx_set = 0, ctx_we = 0, lk_req = 0, lk_store = 0;
    logic rf_we = 0, rf_v = 0, rf_d = 0, fl_req = 0;
    logic [1:0] pfx_id = 0, ctx_id = 0, rf_id = 0, fl_id = 0;
    logic [VW-1:0] lk_vpn = 0, rf_vpn = 0;
    logic [5:0] rf_idx = 0;
    logic [MW-1:0] rf_mask = 0;
    logic [PW-1:0] rf_ppn = 0;
    logic rsp_valid, rsp_hit, rsp_wr, multi_err;
    logic [PW-1:0] rsp_ppn;
    logic [1:0] exc_kind, exc_id;
    logic [31:0] exc_vec;

    int n_chk = 0, n_fail = 0;

    always #(TCLK/2) clk = ~clk;

    mid_tlb u0 (
        .clk(clk), .rst_n(rst_n), .pfx_set(pfx_set), .pfx_id(pfx_id),
        .ctx_we(ctx_we), .ctx_id(ctx_id), .lk_req(lk_req), .lk_store(lk_store),
        .lk_vpn(lk_vpn), .rf_we(rf_we), .rf_idx(rf_idx), .rf_id(rf_id),
        .rf_vpn(rf_vpn), .rf_mask(rf_mask), .rf_ppn(rf_ppn), .rf_v(rf_v),
        .rf_d(rf_d), .fl_req(fl_req), .fl_id(fl_id), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_wr(rsp_wr),
        .exc_kind(exc_kind), .exc_id(exc_id), .exc_vec(exc_vec),
        .multi_err(multi_err)
    );

    // Reference model state.
    logic          m_live [N];
    logic [1:0]    m_id   [N];
    logic [VW-1:0] m_vpn  [N];
    logic [MW-1:0] m_mask [N];
    logic [PW-1:0] m_ppn  [N];
    logic          m_v [N], m_d [N];
    logic          m_pend = 0, m_err = 0;
    logic [1:0]    m_pid = 0, m_ctx = 0;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // One cycle: drive, predict from pre-edge model, advance model, check.
    task automatic op(input bit lk, input bit st, input logic [VW-1:0] vpn,
                      input bit ps, input logic [1:0] pid,
                      input bit cw, input logic [1:0] cid,
                      input bit rw, input int ri, input logic [1:0] rid,
                      input logic [VW-1:0] rv, input logic [MW-1:0] rm,
                      input logic [PW-1:0] rp, input bit rvv, input bit rd,
                      input bit fl, input logic [1:0] fid);
        logic [1:0] eid, ekind;
        int hit_i, cnt;
        logic [PW-1:0] eppn, pm;
        logic [31:0] evec;
        logic ewr;
        lk_req = lk; lk_store = st; lk_vpn = vpn; pfx_set = ps; pfx_id = pid;
        ctx_we = cw; ctx_id = cid; rf_we = rw; rf_idx = 6'(ri); rf_id = rid;
        rf_vpn = rv; rf_mask = rm; rf_ppn = rp; rf_v = rvv; rf_d = rd;
        fl_req = fl; fl_id = fid;
        eid = m_pend ? m_pid : m_ctx;
        hit_i = -1; cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (m_live[i] && m_id[i] == eid &&
                ((m_vpn[i] ^ vpn) & ~{{(VW-MW){1'b0}}, m_mask[i]}) == '0) begin
                cnt++;
                if (hit_i < 0) hit_i = i;
            end
        end
        eppn = '0; ewr = 0;
        if (hit_i < 0)                   ekind = 2'd1;
        else if (!m_v[hit_i])            ekind = 2'd2;
        else if (st && !m_d[hit_i])      ekind = 2'd3;
        else begin
            ekind = 2'd0;
            pm   = {{(PW-MW){1'b0}}, m_mask[hit_i]};
            eppn = (m_ppn[hit_i] & ~pm) | ({{(PW-MW){1'b0}}, vpn[MW-1:0]} & pm);
            ewr  = m_d[hit_i];
        end
        evec = (ekind != 0) ? (eid[1] ? GV : HV) : 32'h0;
        // Advance model.
        if (lk && cnt > 1) m_err = 1;
        if (lk) begin
            if (ekind != 0) m_pend = 0;
            else begin m_pend = ps; if (ps) m_pid = pid; end
        end else if (ps) begin
            m_pend = 1; m_pid = pid;
        end
        if (cw) m_ctx = cid;
        if (fl) for (int i = 0; i < N; i++) if (m_id[i] == fid) m_live[i] = 0;
        if (rw) begin
            m_live[ri] = 1; m_id[ri] = rid; m_vpn[ri] = rv; m_mask[ri] = rm;
            m_ppn[ri] = rp; m_v[ri] = rvv; m_d[ri] = rd;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R5 valid", 64'(rsp_valid), 64'(lk));
        if (lk) begin
            chk("R5 kind", 64'(exc_kind), 64'(ekind));
            chk("R1 ppn", 64'(rsp_ppn), 64'(eppn));
            chk("R1 wr", 64'(rsp_wr), 64'(ewr));
            chk("R6 vec", 64'(exc_vec), 64'(evec));
            chk("R6 id", 64'(exc_id), 64'(eid));
        end
        chk("R9 err", 64'(multi_err), 64'(m_err));
    endtask

    task automatic look(input bit st, input logic [VW-1:0] vpn);
        op(1, st, vpn, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fill(input int ri, input logic [1:0] rid, input logic [VW-1:0] rv,
                        input logic [MW-1:0] rm, input logic [PW-1:0] rp,
                        input bit rvv, input bit rd);
        op(0, 0, 0, 0, 0, 0, 0, 1, ri, rid, rv, rm, rp, rvv, rd, 0, 0);
    endtask

    localparam logic [VW-1:0] VB = 36'h5_0000_0000;

    initial begin
        for (int i = 0; i < N; i++) begin
            m_live[i] = 0; m_id[i] = 0; m_vpn[i] = 0; m_mask[i] = 0;
            m_ppn[i] = 0; m_v[i] = 0; m_d[i] = 0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R10: empty after reset, flag clear.
        chk("R10 err", 64'(multi_err), 0);
        chk("R10 valid", 64'(rsp_valid), 0);
        look(0, VB);
        // R2: context 0 by default, host entry hits without a prefix.
        fill(0, 2'd0, VB, 0, 28'h00A_BC00, 1, 1);
        look(0, VB);
        // R3: guest entry reached only through a prefix, for one lookup.
        fill(1, 2'd2, VB + 1, 0, 28'h0123_450, 1, 0);
        op(0, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(0, VB + 1);
        look(0, VB + 1);
        // R5: store to clean page gives modify, invalid entry gives invalid.
        op(0, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(1, VB + 1);
        fill(2, 2'd0, VB + 2, 0, 28'h77, 0, 1);
        look(0, VB + 2);
        // R4: prefix armed with a hitting lookup survives, with a faulting one is dropped.
        op(1, 0, VB, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(0, VB + 1);
        op(1, 0, VB + 9, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(0, VB + 1);
        // R1: large page, masked low bits come from the lookup VPN.
        fill(3, 2'd0, VB + 36'h20, 2'b11, 28'hABC_DEF0, 1, 1);
        look(0, VB + 36'h23);
        // R7: refill and lookup in the same cycle on the same page.
        op(1, 0, VB + 36'h40, 0, 0, 0, 0, 1, 4, 2'd0, VB + 36'h40, 0, 28'h40, 1, 1, 0, 0);
        look(0, VB + 36'h40);
        // R6/R2: context write to guest 3, miss uses guest vector.
        op(0, 0, 0, 0, 0, 1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(0, VB + 36'h99);
        op(0, 0, 0, 0, 0, 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R8: flush of space 2 leaves host entries.
        op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2);
        look(0, VB);
        op(0, 0, 0, 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        look(0, VB + 1);
        // R9: duplicate match, lowest index wins, flag sticks.
        fill(9, 2'd0, VB + 36'h60, 0, 28'h999, 1, 1);
        fill(5, 2'd0, VB + 36'h60, 0, 28'h555, 1, 1);
        look(0, VB + 36'h60);
        look(0, VB);
        // Random traffic.
        for (int k = 0; k < 4000; k++) begin
            op(($urandom % 10) < 7, $urandom % 2, VB + 36'($urandom % 16),
               ($urandom % 5) == 0, 2'($urandom), ($urandom % 20) == 0, 2'($urandom),
               ($urandom % 4) == 0, int'($urandom % 64), 2'($urandom),
               VB + 36'($urandom % 16), (($urandom % 4) == 0) ? 2'b11 : 2'b00,
               28'($urandom), ($urandom % 7) != 0, ($urandom % 10) < 7,
               ($urandom % 30) == 0, 2'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule